// File: doc/BRIEF.md
# Extended Parallel Port Mode and Register Block

This block is the host-facing register file of an extended parallel port. A byte-wide register bus (address, read strobe, write strobe, write data, registered read data) reaches a data latch, a line-control byte, a status byte, an address for address/data strobe cycles and a mode register. The mode register picks one of four operating modes (standard output, bidirectional byte, FIFO streaming, strobed address/data cycles) and drives the port datapath through plain mode and direction outputs.

The FIFO is modelled only by its fill level. Host writes to the FIFO address add a byte. The datapath drains bytes through a valid/ready pair: `drain_valid` is high whenever the level is non-zero in FIFO mode, a byte leaves on every cycle in which `drain_valid` and `drain_ready` are both high, and the datapath may hold `drain_ready` low for as long as it likes without loss. A strobed cycle that is not acknowledged in time raises a sticky timeout flag in status bit 0, and software clears it with a two-write sequence.

Register addresses: 0 data, 1 status, 2 line control, 3 strobed-cycle byte, 4 FIFO push, 5 mode register. Mode register layout: bits 7:5 mode code, bits 4:2 read 0, bit 1 FIFO full, bit 0 FIFO empty.

Top module: `pp_mode_regs`

## Requirements
- R1: After reset the mode register reads 0x01, data and line control read 0x00, status bit 0 reads 0, `port_mode` is 000 and `pins_oe` is 1.
- R2: A byte written to the data address reads back unchanged (0xAA written reads 0xAA) while `pins_oe` is 1, and drives `pins_dout`; while `pins_oe` is 0 a data read returns `pins_din`.
- R3: A byte written to the line-control address appears on `ctrl_out` after the write and reads back unchanged.
- R4: Mode codes 000 (standard), 001 (bidirectional), 011 (FIFO) and 100 (strobed cycles) written in bits 7:5 of the mode register are taken and read back in bits 7:5; so writes of 0x00, 0x20, 0x60, 0x80 read back 0x01, 0x21, 0x61, 0x81 with an empty FIFO. Bits 4:2 always read 0.
- R5: A mode-register write carrying code 010, 101, 110 or 111 is ignored: the mode and the FIFO level keep their values.
- R6: Mode register bit 0 reads 1 exactly when the FIFO level is zero; bit 1 reads 1 exactly when the level equals `FIFO_DEPTH`.
- R7: Writes to the FIFO address raise the level by one only in FIFO mode (011) and only below `FIFO_DEPTH`; pushes at a full FIFO and pushes in any other mode are dropped.
- R8: `drain_valid` is high only in FIFO mode with a non-zero level; each cycle with `drain_valid` and `drain_ready` both high removes one byte, and a push and a drain in the same cycle leave the level unchanged.
- R9: The FIFO level clears when a legal code different from the current mode is written; rewriting the current mode keeps it.
- R10: `pins_oe` is 0 only in bidirectional mode with line-control bit 5 set; in every other case it is 1.
- R11: A write to the strobed-cycle address in mode 100 raises `epp_strobe` from the next cycle, drives the byte on `pins_dout`, and ends one cycle after `epp_ack` is seen; such writes in other modes start nothing.
- R12: A strobed cycle without acknowledge keeps `epp_strobe` high for `EPP_TIMEOUT` cycles, then drops it and sets status bit 0; status bits 7:1 always show `stat_in`.
- R13: Status bit 0 clears only on a status write with bit 0 clear that directly follows a status write with bit 0 set; a lone write with bit 0 clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; read data is registered |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| pins_din | input | 8 | Data lines as seen on the cable |
| stat_in | input | 7 | Cable status lines, shown in status bits 7:1 |
| pins_dout | output | 8 | Data lines driven toward the cable |
| pins_oe | output | 1 | Data line output enable |
| ctrl_out | output | 8 | Line-control byte |
| port_mode | output | 3 | Current mode code |
| epp_strobe | output | 1 | Strobed cycle in progress |
| epp_ack | input | 1 | Acknowledge from the cable side |
| drain_valid | output | 1 | A FIFO byte is available to the datapath |
| drain_ready | input | 1 | Datapath takes a FIFO byte |

## Verification
Every register write takes effect at the clock edge that samples it, so its effect on outputs and on a later read is due one cycle later; read data appears one cycle after the read strobe. A strobe starts the cycle after the launching write and ends one cycle after acknowledge, or after exactly `EPP_TIMEOUT` cycles, the edge that also sets the timeout flag. The bench drives on falling edges and samples on the next falling edge, counting edges from the launching write when it checks the strobe's last high cycle and its first low one.

// File: rtl/ppmr_pkg.sv
package ppmr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RA_W   = 3;
  localparam int unsigned N_REGS = 6;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_FIFO  = 3'b011,
    MODE_EPP   = 3'b100
  } pmode_e;

  localparam logic [RA_W-1:0] RA_DATA = 3'd0;
  localparam logic [RA_W-1:0] RA_STAT = 3'd1;
  localparam logic [RA_W-1:0] RA_CTRL = 3'd2;
  localparam logic [RA_W-1:0] RA_EPPD = 3'd3;
  localparam logic [RA_W-1:0] RA_FIFO = 3'd4;
  localparam logic [RA_W-1:0] RA_ECR  = 3'd5;

  localparam int unsigned DIR_BIT = 5;

  function automatic logic code_ok(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b011) || (c == 3'b100);
  endfunction
endpackage

// File: rtl/ppmr_mode_sel.sv
module ppmr_mode_sel
  import ppmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ecr_we,
  input  logic [2:0] code,
  output pmode_e     mode,
  output logic       change
);
  // only a legal code that differs from the present mode counts as a change
  assign change = ecr_we && code_ok(code) && (code != mode);

  always_ff @(posedge clk) begin
    if (!rst_n)      mode <= MODE_STD;
    else if (change) mode <= pmode_e'(code);
  end
endmodule

// File: rtl/ppmr_fill_ctr.sv
module ppmr_fill_ctr #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  input  logic push,
  input  logic drain_ready,
  output logic empty,
  output logic full,
  output logic drain_valid
);
  localparam logic [CW-1:0] LVL_MAX = CW'(DEPTH);

  logic [CW-1:0] level;
  logic pop_ok, push_ok;

  assign empty       = (level == '0);
  assign full        = (level == LVL_MAX);
  assign drain_valid = enable && !empty;
  assign pop_ok      = drain_valid && drain_ready;
  // a full FIFO still takes a byte when one leaves in the same cycle
  assign push_ok     = push && enable && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)       level <= '0;
    else if (push_ok && !pop_ok) level <= level + 1'b1;
    else if (pop_ok && !push_ok) level <= level - 1'b1;
  end
endmodule

// File: rtl/ppmr_epp_seq.sv
module ppmr_epp_seq #(
  parameter int unsigned TIMEOUT_CYC = 8,
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ack,
  input  logic abort,
  output logic busy,
  output logic expire
);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] waited;

  assign expire = busy && !ack && !abort && (waited == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      waited <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      waited <= '0;
    end else if (busy) begin
      if (ack || expire) busy <= 1'b0;
      else               waited <= waited + 1'b1;
    end
  end
endmodule

// File: rtl/ppmr_tmo_flag.sv
module ppmr_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr,
  input  logic wbit0,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (wr) armed <= wbit0;
      if (set)                        flag <= 1'b1;
      else if (wr && !wbit0 && armed) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pp_mode_regs.sv
module pp_mode_regs
  import ppmr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned EPP_TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] pins_din,
  input  logic [BYTE_W-2:0] stat_in,
  output logic [BYTE_W-1:0] pins_dout,
  output logic              pins_oe,
  output logic [BYTE_W-1:0] ctrl_out,
  output logic [2:0]        port_mode,
  output logic              epp_strobe,
  input  logic              epp_ack,
  output logic              drain_valid,
  input  logic              drain_ready
);
  logic [N_REGS-1:0] wsel;
  pmode_e            mode;
  logic              mode_chg;
  logic              fifo_empty, fifo_full;
  logic              epp_start, epp_abort, epp_expire;
  logic              to_flag;
  logic [BYTE_W-1:0] data_q, ctrl_q, epp_q, rd_mux;

  for (genvar i = 0; i < N_REGS; i++) begin : g_wdec
    assign wsel[i] = bus_wr && (bus_addr == RA_W'(i));
  end

  ppmr_mode_sel u_mode (
    .clk(clk), .rst_n(rst_n),
    .ecr_we(wsel[RA_ECR]), .code(bus_wdata[7:5]),
    .mode(mode), .change(mode_chg)
  );

  ppmr_fill_ctr #(.DEPTH(FIFO_DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n),
    .enable(mode == MODE_FIFO), .clear(mode_chg),
    .push(wsel[RA_FIFO]), .drain_ready(drain_ready),
    .empty(fifo_empty), .full(fifo_full), .drain_valid(drain_valid)
  );

  assign epp_start = wsel[RA_EPPD] && (mode == MODE_EPP) && !epp_strobe;
  assign epp_abort = mode_chg || (mode != MODE_EPP);

  ppmr_epp_seq #(.TIMEOUT_CYC(EPP_TIMEOUT)) u_epp (
    .clk(clk), .rst_n(rst_n),
    .start(epp_start), .ack(epp_ack), .abort(epp_abort),
    .busy(epp_strobe), .expire(epp_expire)
  );

  ppmr_tmo_flag u_flag (
    .clk(clk), .rst_n(rst_n),
    .set(epp_expire), .wr(wsel[RA_STAT]), .wbit0(bus_wdata[0]),
    .flag(to_flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      epp_q  <= '0;
    end else begin
      if (wsel[RA_DATA]) data_q <= bus_wdata;
      if (wsel[RA_CTRL]) ctrl_q <= bus_wdata;
      if (epp_start)     epp_q  <= bus_wdata;
    end
  end

  assign pins_oe   = !((mode == MODE_BIDIR) && ctrl_q[DIR_BIT]);
  assign pins_dout = epp_strobe ? epp_q : data_q;
  assign ctrl_out  = ctrl_q;
  assign port_mode = mode;

  always_comb begin
    unique case (bus_addr)
      RA_DATA: rd_mux = pins_oe ? data_q : pins_din;
      RA_STAT: rd_mux = {stat_in, to_flag};
      RA_CTRL: rd_mux = ctrl_q;
      RA_EPPD: rd_mux = epp_q;
      RA_ECR:  rd_mux = {mode, 3'b000, fifo_full, fifo_empty};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ppmr_checker.sv
module ppmr_checker
  import ppmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [RA_W-1:0]   bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [2:0]        port_mode,
  input logic              pins_oe,
  input logic [BYTE_W-1:0] ctrl_out,
  input logic              epp_strobe,
  input logic              epp_ack,
  input logic              drain_valid,
  input logic              to_flag
);
  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(port_mode));

  // R5
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_ECR && !code_ok(bus_wdata[7:5])) |=> $stable(port_mode));

  // R8
  drain_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> (port_mode == MODE_FIFO));

  // R9
  clear_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_ECR && code_ok(bus_wdata[7:5]) && bus_wdata[7:5] != port_mode)
      |=> !drain_valid);

  // R10
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_oe |-> (port_mode == MODE_BIDIR && ctrl_out[DIR_BIT]));

  // R11
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epp_strobe |-> (port_mode == MODE_EPP));

  // R11
  ack_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (epp_strobe && epp_ack) |=> !epp_strobe);

  // R12
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_flag) |-> $past(epp_strobe));
endmodule

bind pp_mode_regs ppmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .port_mode(port_mode), .pins_oe(pins_oe),
  .ctrl_out(ctrl_out), .epp_strobe(epp_strobe), .epp_ack(epp_ack),
  .drain_valid(drain_valid), .to_flag(to_flag)
);

// File: tb/pp_mode_regs_test.sv
module pp_mode_regs_test;
  localparam int DEPTH = 16;
  localparam int TMO   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pins_din = 8'h5C;
  logic [6:0] stat_in = 7'h55;
  logic [7:0] pins_dout, ctrl_out;
  logic       pins_oe, epp_strobe, drain_valid;
  logic [2:0] port_mode;
  logic       epp_ack = 1'b0, drain_ready = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pp_mode_regs #(.FIFO_DEPTH(DEPTH), .EPP_TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_din(pins_din), .stat_in(stat_in), .pins_dout(pins_dout),
    .pins_oe(pins_oe), .ctrl_out(ctrl_out), .port_mode(port_mode),
    .epp_strobe(epp_strobe), .epp_ack(epp_ack),
    .drain_valid(drain_valid), .drain_ready(drain_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic drain(output int n);
    n = 0;
    drain_ready = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (drain_valid) n++;
      @(negedge clk);
    end
    drain_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd5, v); chk("R1 ecr", v, 8'h01);
    rd(3'd0, v); chk("R1 data", v, 8'h00);
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk("R1 status bit0", v[0], 1'b0);
    chk("R1 port_mode", port_mode, 3'b000);
    chk("R1 pins_oe", pins_oe, 1'b1);
  endtask

  task automatic t_presence();
    logic [7:0] v;
    wr(3'd2, 8'h0C);
    chk("R3 ctrl_out", ctrl_out, 8'h0C);
    rd(3'd2, v); chk("R3 ctrl readback", v, 8'h0C);
    wr(3'd0, 8'hAA);
    rd(3'd0, v); chk("R2 data readback", v, 8'hAA);
    chk("R2 pins_dout", pins_dout, 8'hAA);
  endtask

  task automatic t_modes();
    logic [7:0] v;
    wr(3'd5, 8'h20); rd(3'd5, v); chk("R4 bidir", v, 8'h21);
    chk("R4 port_mode bidir", port_mode, 3'b001);
    wr(3'd5, 8'h60); rd(3'd5, v); chk("R4 fifo", v, 8'h61);
    wr(3'd5, 8'h80); rd(3'd5, v); chk("R4 epp", v, 8'h81);
    chk("R4 port_mode epp", port_mode, 3'b100);
    wr(3'd5, 8'h3C); rd(3'd5, v); chk("R4 bits 4:2 read 0", v, 8'h21);
    wr(3'd5, 8'h00); rd(3'd5, v); chk("R4 std", v, 8'h01);
  endtask

  task automatic t_illegal();
    logic [7:0] v;
    wr(3'd5, 8'h60);
    wr(3'd4, 8'h11);
    for (int c = 0; c < 4; c++) begin
      logic [2:0] bad;
      bad = (c == 0) ? 3'b010 : (c == 1) ? 3'b101 : (c == 2) ? 3'b110 : 3'b111;
      wr(3'd5, {bad, 5'b0});
      rd(3'd5, v); chk("R5 bad code ignored", v, 8'h60);
    end
    wr(3'd5, 8'h00);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    int n;
    wr(3'd5, 8'h60);
    for (int i = 0; i < 3; i++) wr(3'd4, 8'(i));
    rd(3'd5, v); chk("R6 partial level flags", v, 8'h60);
    chk("R8 drain_valid with data", drain_valid, 1'b1);
    for (int i = 3; i < DEPTH; i++) wr(3'd4, 8'(i));
    rd(3'd5, v); chk("R6 full flag", v, 8'h62);
    wr(3'd4, 8'hFF);
    drain(n); chk("R7 overflow dropped", n, DEPTH);
    rd(3'd5, v); chk("R6 empty after drain", v, 8'h61);
    wr(3'd4, 8'h01); wr(3'd4, 8'h02);
    @(negedge clk); bus_addr = 3'd4; bus_wr = 1'b1; drain_ready = 1'b1;
    @(negedge clk); bus_wr = 1'b0; drain_ready = 1'b0;
    drain(n); chk("R8 push with drain keeps level", n, 2);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h01); wr(3'd4, 8'h02);
    chk("R8 no drain_valid in std", drain_valid, 1'b0);
    rd(3'd5, v); chk("R7 push ignored in std", v, 8'h01);
  endtask

  task automatic t_clear_on_change();
    logic [7:0] v;
    wr(3'd5, 8'h60);
    wr(3'd4, 8'h01); wr(3'd4, 8'h02);
    wr(3'd5, 8'h60);
    rd(3'd5, v); chk("R9 same code keeps level", v, 8'h60);
    wr(3'd5, 8'h20);
    wr(3'd5, 8'h60);
    rd(3'd5, v); chk("R9 level cleared on change", v, 8'h61);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_direction();
    logic [7:0] v;
    wr(3'd2, 8'h20);
    chk("R10 std always drives", pins_oe, 1'b1);
    wr(3'd5, 8'h20);
    chk("R10 bidir reverse", pins_oe, 1'b0);
    rd(3'd0, v); chk("R2 reverse read returns pins", v, 8'h5C);
    wr(3'd2, 8'h00);
    chk("R10 bidir forward", pins_oe, 1'b1);
    rd(3'd0, v); chk("R2 forward read returns latch", v, 8'hAA);
    wr(3'd2, 8'h20); wr(3'd5, 8'h60);
    chk("R10 fifo mode drives", pins_oe, 1'b1);
    wr(3'd2, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_epp_ack();
    logic [7:0] v;
    wr(3'd3, 8'h33);
    chk("R11 no cycle outside mode", epp_strobe, 1'b0);
    wr(3'd5, 8'h80);
    wr(3'd3, 8'h33);
    chk("R11 strobe up", epp_strobe, 1'b1);
    chk("R11 byte on pins", pins_dout, 8'h33);
    epp_ack = 1'b1;
    @(negedge clk); epp_ack = 1'b0;
    chk("R11 strobe ends after ack", epp_strobe, 1'b0);
    rd(3'd1, v); chk("R12 no timeout after ack", v, 8'hAA);
  endtask

  task automatic t_epp_timeout();
    logic [7:0] v;
    stat_in = 7'h12;
    wr(3'd3, 8'h44);
    repeat (TMO - 1) @(negedge clk);
    chk("R12 strobe held for timeout", epp_strobe, 1'b1);
    @(negedge clk);
    chk("R12 strobe dropped at timeout", epp_strobe, 1'b0);
    rd(3'd1, v); chk("R12 status after timeout", v, 8'h25);
  endtask

  task automatic t_flag_clear();
    logic [7:0] v;
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R13 lone clear write", v[0], 1'b1);
    wr(3'd1, 8'h01);
    rd(3'd1, v); chk("R13 arming write", v[0], 1'b1);
    wr(3'd1, 8'h01); wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R13 two-write clear", v[0], 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_presence();
    t_modes();
    t_illegal();
    t_fifo();
    t_clear_on_change();
    t_direction();
    t_epp_ack();
    t_epp_timeout();
    t_flag_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule